// File: doc/BRIEF.md
# Indirect Capability Register Window

This block is a three-word capability structure inside a configuration register space. A host reaches it through a simple 32-bit read/write port addressed by byte offset. Offset 0 holds a read-only header word with fixed capability fields. Offset 4 holds an operation-select word made of a FUNCTION field and an INDEX field. Offset 8 is a data window. Every read or write of the window goes to whichever internal register the operation-select word currently names.

Behind the window sit the control and status registers of a page-exclusion checker. These are a bank of base-low words and a bank of base-high words, one pair per protection domain, a bank of mapping words, a read-only capability word, a control word and three error registers that the checker supplies. The block drives the writable registers out to the checker and returns the checker's error values on reads. The control word's flush bit reads 1 from the moment software sets it until the checker signals that the flush has finished.

Top module: `capwin_top`

## Requirements
- R1: A read at byte offset 0 returns the header {10'b0, INT_CAP at bit 21, MCE_CAP at bit 20, bit 19 = 0, bits 18:16 = 000b, NEXT_PTR at bits 15:8, 8'h0F at bits 7:0}. Writes to offset 0 change nothing.
- R2: A write at offset 4 stores wdata[15:8] as FUNCTION and wdata[7:0] as INDEX. A read at offset 4 returns {16'h0, FUNCTION, INDEX}.
- R3: With FUNCTION 0 and INDEX below NDOM, a write at offset 8 updates that domain's base-low word, which appears on base_lo_o[32*INDEX +: 32]. A read at offset 8 returns that word.
- R4: With FUNCTION 1 and INDEX below NDOM, the window reads and writes that domain's base-high word, which appears on base_hi_o[32*INDEX +: 32].
- R5: With FUNCTION 2 and INDEX below NMAP, the window reads and writes mapping word INDEX, which appears on map_o[32*INDEX +: 32].
- R6: FUNCTION codes 3 to 7 name single registers, and INDEX has no effect on which register they reach. Code 4 is the control word, seen on ctrl_o.
- R7: FUNCTION 3 reads the capability word {16'h0, NMAP[7:0], NDOM[7:0]}. Window writes to it are ignored.
- R8: FUNCTION 5, 6 and 7 read err_status_i, err_addr_lo_i and err_addr_hi_i in the same cycle. Window writes to them are ignored.
- R9: A FUNCTION of 8 or above reads as zero, and window writes with it leave every output unchanged.
- R10: For FUNCTION 0 or 1 with INDEX of NDOM or above, or FUNCTION 2 with INDEX of NMAP or above, the window reads zero and writes leave every output unchanged.
- R11: Control bit 1 is the flush bit. A window write with that bit at 1 sets it. A write with it at 0 does not clear it. It stays 1 until a cycle with flush_done_i high and no new set, and then reads 0. A set and flush_done_i in the same cycle leave it at 1.
- R12: Reset clears the operation-select word and every writable register to zero.
- R13: An address with cfg_addr[1:0] not zero, or with cfg_addr[3:2] equal to 3, reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 4 | Byte offset within the capability structure |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, combinational |
| flush_done_i | input | 1 | Checker reports that the flush has completed |
| err_status_i | input | 32 | Checker error status |
| err_addr_lo_i | input | 32 | Checker error address, low word |
| err_addr_hi_i | input | 32 | Checker error address, high word |
| base_lo_o | output | 32*NDOM | Base-low word of each domain |
| base_hi_o | output | 32*NDOM | Base-high word of each domain |
| map_o | output | 32*NMAP | Mapping words |
| ctrl_o | output | 32 | Control word, flush at bit 1 |

## Verification
A wrong operation-select decode steers a window write into a neighbouring register. That error shows on the flattened register outputs at the next clock edge, and on a later window read of the intended register as a missing value. Because reads are combinational, a wrong read mux or a wrong index bound shows on cfg_rdata in the same cycle the address is applied. A flush bit that clears too early or stays stuck reads wrong on the first window read after the flush_done_i pulse. The sweep therefore writes a distinct pattern to every index, including indices past the bounds, of each multi-instance group. It then reads them all back and compares the full output vectors against a model in the bench.

// File: rtl/capwin_pkg.sv
package capwin_pkg;
  localparam int WORD_W = 32;

  // word slots decoded from cfg_addr[3:2]
  localparam logic [1:0] SLOT_HDR   = 2'd0;
  localparam logic [1:0] SLOT_OPSEL = 2'd1;
  localparam logic [1:0] SLOT_WIN   = 2'd2;

  // function codes
  localparam logic [7:0] FN_BASE_LO = 8'd0;
  localparam logic [7:0] FN_BASE_HI = 8'd1;
  localparam logic [7:0] FN_MAP     = 8'd2;
  localparam logic [7:0] FN_CAP     = 8'd3;
  localparam logic [7:0] FN_CTRL    = 8'd4;
  localparam logic [7:0] FN_ERR_ST  = 8'd5;
  localparam logic [7:0] FN_ERR_ALO = 8'd6;
  localparam logic [7:0] FN_ERR_AHI = 8'd7;
  localparam int         NUM_FN     = 8;

  localparam int FLUSH_BIT = 1;

  function automatic logic [WORD_W-1:0] hdr_word(input logic [7:0] nxt,
                                                 input logic mce,
                                                 input logic intr);
    return {10'd0, intr, mce, 1'b0, 3'b000, nxt, 8'h0F};
  endfunction

  function automatic logic [WORD_W-1:0] cap_word(input int ndom, input int nmap);
    return {16'd0, 8'(nmap), 8'(ndom)};
  endfunction

  function automatic logic idx_below(input logic [7:0] idx, input int n);
    return int'(idx) < n;
  endfunction
endpackage

// File: rtl/capwin_opsel.sv
module capwin_opsel
  import capwin_pkg::*;
#(
  parameter int NDOM = 4,
  parameter int NMAP = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wdata,
  output logic [7:0]        fn_code,
  output logic [7:0]        idx,
  output logic              fn_valid,
  output logic              fn_multi,
  output logic              idx_valid,
  output logic [NUM_FN-1:0] sel
);
  logic [15:0] op_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     op_q <= '0;
    else if (wr_en) op_q <= wdata;
  end

  assign fn_code  = op_q[15:8];
  assign idx      = op_q[7:0];
  assign fn_valid = idx_below(fn_code, NUM_FN);
  assign fn_multi = (fn_code == FN_BASE_LO) || (fn_code == FN_BASE_HI) ||
                    (fn_code == FN_MAP);

  always_comb begin
    unique case (fn_code)
      FN_BASE_LO, FN_BASE_HI: idx_valid = idx_below(idx, NDOM);
      FN_MAP:                 idx_valid = idx_below(idx, NMAP);
      default:                idx_valid = 1'b1;
    endcase
  end

  // one-hot target: code match, and index in range for multi groups
  for (genvar g = 0; g < NUM_FN; g++) begin : g_sel
    assign sel[g] = (fn_code == 8'(g)) && idx_valid;
  end
endmodule

// File: rtl/capwin_bank.sv
module capwin_bank
  import capwin_pkg::*;
#(
  parameter int N = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [7:0]          idx,
  input  logic [WORD_W-1:0]   wdata,
  output logic [N*WORD_W-1:0] q_flat,
  output logic [WORD_W-1:0]   rd_data
);
  logic [WORD_W-1:0] q [N];

  for (genvar i = 0; i < N; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                       q[i] <= '0;
      else if (wr_en && idx == 8'(i))   q[i] <= wdata;
    end
    assign q_flat[i*WORD_W +: WORD_W] = q[i];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N; i++) begin
      if (idx == 8'(i)) rd_data = q[i];
    end
  end
endmodule

// File: rtl/capwin_ctrl.sv
module capwin_ctrl
  import capwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic              flush_done_i,
  output logic [WORD_W-1:0] ctrl_q
);
  logic [WORD_W-1:0] ctrl_nxt;
  logic              flush_set;

  assign flush_set = wr_en && wdata[FLUSH_BIT];

  always_comb begin
    ctrl_nxt = wr_en ? wdata : ctrl_q;
    // hardware owns clearing; a fresh set wins over a same-cycle done
    ctrl_nxt[FLUSH_BIT] = flush_set || (ctrl_q[FLUSH_BIT] && !flush_done_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_nxt;
  end
endmodule

// File: rtl/capwin_top.sv
module capwin_top
  import capwin_pkg::*;
#(
  parameter int         NDOM     = 4,
  parameter int         NMAP     = 6,
  parameter logic [7:0] NEXT_PTR = 8'h40,
  parameter bit         MCE_CAP  = 1'b1,
  parameter bit         INT_CAP  = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [3:0]             cfg_addr,
  input  logic                   cfg_wr,
  input  logic [WORD_W-1:0]      cfg_wdata,
  output logic [WORD_W-1:0]      cfg_rdata,
  input  logic                   flush_done_i,
  input  logic [WORD_W-1:0]      err_status_i,
  input  logic [WORD_W-1:0]      err_addr_lo_i,
  input  logic [WORD_W-1:0]      err_addr_hi_i,
  output logic [NDOM*WORD_W-1:0] base_lo_o,
  output logic [NDOM*WORD_W-1:0] base_hi_o,
  output logic [NMAP*WORD_W-1:0] map_o,
  output logic [WORD_W-1:0]      ctrl_o
);
  localparam logic [WORD_W-1:0] HDR_VAL = hdr_word(NEXT_PTR, MCE_CAP, INT_CAP);
  localparam logic [WORD_W-1:0] CAP_VAL = cap_word(NDOM, NMAP);

  // address decode
  logic aligned, hit_hdr, hit_opsel, hit_win;
  assign aligned   = (cfg_addr[1:0] == 2'b00);
  assign hit_hdr   = aligned && (cfg_addr[3:2] == SLOT_HDR);
  assign hit_opsel = aligned && (cfg_addr[3:2] == SLOT_OPSEL);
  assign hit_win   = aligned && (cfg_addr[3:2] == SLOT_WIN);

  logic opsel_wr, win_wr;
  assign opsel_wr = cfg_wr && hit_opsel;
  assign win_wr   = cfg_wr && hit_win;

  // operation select
  logic [7:0]        fn_code, idx;
  logic              fn_valid, fn_multi, idx_valid;
  logic [NUM_FN-1:0] sel;

  capwin_opsel #(.NDOM(NDOM), .NMAP(NMAP)) u_opsel (
    .clk(clk), .rst_n(rst_n), .wr_en(opsel_wr), .wdata(cfg_wdata[15:0]),
    .fn_code(fn_code), .idx(idx), .fn_valid(fn_valid), .fn_multi(fn_multi),
    .idx_valid(idx_valid), .sel(sel)
  );

  // register groups
  logic [WORD_W-1:0] lo_rd, hi_rd, map_rd;

  capwin_bank #(.N(NDOM)) u_base_lo (
    .clk(clk), .rst_n(rst_n), .wr_en(win_wr && sel[FN_BASE_LO]), .idx(idx),
    .wdata(cfg_wdata), .q_flat(base_lo_o), .rd_data(lo_rd)
  );

  capwin_bank #(.N(NDOM)) u_base_hi (
    .clk(clk), .rst_n(rst_n), .wr_en(win_wr && sel[FN_BASE_HI]), .idx(idx),
    .wdata(cfg_wdata), .q_flat(base_hi_o), .rd_data(hi_rd)
  );

  capwin_bank #(.N(NMAP)) u_map (
    .clk(clk), .rst_n(rst_n), .wr_en(win_wr && sel[FN_MAP]), .idx(idx),
    .wdata(cfg_wdata), .q_flat(map_o), .rd_data(map_rd)
  );

  capwin_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(win_wr && sel[FN_CTRL]),
    .wdata(cfg_wdata), .flush_done_i(flush_done_i), .ctrl_q(ctrl_o)
  );

  // window read: sel is one-hot or zero
  logic [WORD_W-1:0] win_rd;
  assign win_rd = ({WORD_W{sel[FN_BASE_LO]}} & lo_rd)
                | ({WORD_W{sel[FN_BASE_HI]}} & hi_rd)
                | ({WORD_W{sel[FN_MAP]}}     & map_rd)
                | ({WORD_W{sel[FN_CAP]}}     & CAP_VAL)
                | ({WORD_W{sel[FN_CTRL]}}    & ctrl_o)
                | ({WORD_W{sel[FN_ERR_ST]}}  & err_status_i)
                | ({WORD_W{sel[FN_ERR_ALO]}} & err_addr_lo_i)
                | ({WORD_W{sel[FN_ERR_AHI]}} & err_addr_hi_i);

  always_comb begin
    if (hit_hdr)        cfg_rdata = HDR_VAL;
    else if (hit_opsel) cfg_rdata = {16'd0, fn_code, idx};
    else if (hit_win)   cfg_rdata = win_rd;
    else                cfg_rdata = '0;
  end
endmodule

// File: rtl/capwin_chk.sv
module capwin_chk
  import capwin_pkg::*;
#(
  parameter int         NDOM     = 4,
  parameter int         NMAP     = 6,
  parameter logic [7:0] NEXT_PTR = 8'h40,
  parameter bit         MCE_CAP  = 1'b1,
  parameter bit         INT_CAP  = 1'b0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [3:0]             cfg_addr,
  input logic [WORD_W-1:0]      cfg_rdata,
  input logic                   flush_done_i,
  input logic [WORD_W-1:0]      err_status_i,
  input logic [NDOM*WORD_W-1:0] base_lo_o,
  input logic [NDOM*WORD_W-1:0] base_hi_o,
  input logic [NMAP*WORD_W-1:0] map_o,
  input logic [WORD_W-1:0]      ctrl_o,
  input logic                   win_wr,
  input logic [7:0]             fn_code,
  input logic                   fn_valid,
  input logic                   fn_multi,
  input logic                   idx_valid
);
  a_r1_header: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr == 4'd0 |-> cfg_rdata == hdr_word(NEXT_PTR, MCE_CAP, INT_CAP));

  a_r2_opsel_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr == 4'd4 |-> cfg_rdata[31:16] == 16'd0);

  a_r8_err_status: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 4'd8 && fn_code == FN_ERR_ST) |-> cfg_rdata == err_status_i);

  a_r9_bad_fn_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && !fn_valid) |=> ($stable(base_lo_o) && $stable(base_hi_o) &&
                                $stable(map_o) && $stable(ctrl_o)));

  a_r10_bad_idx_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && fn_multi && !idx_valid) |=> ($stable(base_lo_o) && $stable(base_hi_o) &&
                                            $stable(map_o) && $stable(ctrl_o)));

  a_r11_flush_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[FLUSH_BIT] && !flush_done_i) |=> ctrl_o[FLUSH_BIT]);

  a_r11_flush_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[FLUSH_BIT] && flush_done_i && !win_wr) |=> !ctrl_o[FLUSH_BIT]);

  a_r13_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr[1:0] != 2'b00 || cfg_addr[3:2] == 2'd3) |-> cfg_rdata == '0);
endmodule

bind capwin_top capwin_chk #(
  .NDOM(NDOM), .NMAP(NMAP), .NEXT_PTR(NEXT_PTR), .MCE_CAP(MCE_CAP), .INT_CAP(INT_CAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .flush_done_i(flush_done_i), .err_status_i(err_status_i),
  .base_lo_o(base_lo_o), .base_hi_o(base_hi_o), .map_o(map_o), .ctrl_o(ctrl_o),
  .win_wr(win_wr), .fn_code(fn_code), .fn_valid(fn_valid), .fn_multi(fn_multi),
  .idx_valid(idx_valid)
);

// File: tb/tb_capwin_top.sv
module tb_capwin_top;
  localparam int CLK_PERIOD = 10;
  localparam int NDOM = 4;
  localparam int NMAP = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [3:0]        cfg_addr = '0;
  logic              cfg_wr = 1'b0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       cfg_rdata;
  logic              flush_done_i = 1'b0;
  logic [31:0]       err_status_i = '0, err_addr_lo_i = '0, err_addr_hi_i = '0;
  logic [NDOM*32-1:0] base_lo_o, base_hi_o;
  logic [NMAP*32-1:0] map_o;
  logic [31:0]       ctrl_o;

  capwin_top #(.NDOM(NDOM), .NMAP(NMAP), .NEXT_PTR(8'h40), .MCE_CAP(1'b1), .INT_CAP(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .flush_done_i(flush_done_i), .err_status_i(err_status_i),
    .err_addr_lo_i(err_addr_lo_i), .err_addr_hi_i(err_addr_hi_i),
    .base_lo_o(base_lo_o), .base_hi_o(base_hi_o), .map_o(map_o), .ctrl_o(ctrl_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_lo [NDOM];
  logic [31:0] m_hi [NDOM];
  logic [31:0] m_map [NMAP];
  logic [31:0] m_ctrl;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic pick(input int fn, input int ix);
    wr(4'd4, {16'd0, 8'(fn), 8'(ix)});
  endtask

  function automatic logic [31:0] pat(input int fn, input int ix);
    return 32'hC0DE_0001 ^ (32'(fn) << 12) ^ (32'(ix) << 4) ^ (32'(ix) << 24);
  endfunction

  function automatic int lim(input int fn);
    return (fn == 2) ? NMAP : NDOM;
  endfunction

  task automatic chk_outputs(input string req);
    for (int i = 0; i < NDOM; i++) begin
      chk(req, base_lo_o[i*32 +: 32], m_lo[i]);
      chk(req, base_hi_o[i*32 +: 32], m_hi[i]);
    end
    for (int i = 0; i < NMAP; i++) chk(req, map_o[i*32 +: 32], m_map[i]);
    chk(req, ctrl_o, m_ctrl);
  endtask

  task automatic model_write(input int fn, input int ix, input logic [31:0] d);
    if (fn == 0 && ix < NDOM) m_lo[ix] = d;
    if (fn == 1 && ix < NDOM) m_hi[ix] = d;
    if (fn == 2 && ix < NMAP) m_map[ix] = d;
  endtask

  function automatic logic [31:0] model_read(input int fn, input int ix);
    if (fn == 0) return (ix < NDOM) ? m_lo[ix] : 32'h0;
    if (fn == 1) return (ix < NDOM) ? m_hi[ix] : 32'h0;
    return (ix < NMAP) ? m_map[ix] : 32'h0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < NDOM; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    for (int i = 0; i < NMAP; i++) m_map[i] = '0;
    m_ctrl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    rd(4'd4, v); chk("R12 opsel after reset", v, 32'h0);
    chk_outputs("R12 outputs after reset");

    // R1 header, write ignored
    rd(4'd0, v); chk("R1 header", v, 32'h0010_400F);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, v); chk("R1 header after write", v, 32'h0010_400F);

    // R2 opsel reserved bits
    wr(4'd4, 32'hFFFF_0305);
    rd(4'd4, v); chk("R2 opsel readback", v, 32'h0000_0305);

    // R3 R4 R5 R10 sweep over groups and indices including out of range
    for (int fn = 0; fn < 3; fn++) begin
      for (int ix = 0; ix < 8; ix++) begin
        pick(fn, ix);
        wr(4'd8, pat(fn, ix));
        model_write(fn, ix, pat(fn, ix));
      end
    end
    for (int fn = 0; fn < 3; fn++) begin
      for (int ix = 0; ix < 8; ix++) begin
        pick(fn, ix);
        rd(4'd8, v);
        if (ix >= lim(fn)) chk("R10 out-of-range index reads zero", v, 32'h0);
        else if (fn == 0)  chk("R3 base-low readback", v, model_read(fn, ix));
        else if (fn == 1)  chk("R4 base-high readback", v, model_read(fn, ix));
        else               chk("R5 mapping readback", v, model_read(fn, ix));
      end
    end
    chk_outputs("R10 outputs after sweep");

    // R7 capability word, read-only, index ignored
    for (int ix = 0; ix < 3; ix++) begin
      pick(3, ix * 7);
      wr(4'd8, 32'hDEAD_BEEF);
      rd(4'd8, v); chk("R7 capability word", v, 32'h0000_0604);
    end

    // R6 control reached with any index
    pick(4, 0);
    wr(4'd8, 32'h0000_00F5); m_ctrl = 32'h0000_00F5;
    pick(4, 9);
    rd(4'd8, v); chk("R6 control via other index", v, 32'h0000_00F5);
    wr(4'd8, 32'h1234_5670); m_ctrl = 32'h1234_5670;
    pick(4, 200);
    rd(4'd8, v); chk("R6 control write via index 9", v, 32'h1234_5670);
    chk("R6 ctrl_o", ctrl_o, m_ctrl);

    // R8 error registers follow inputs, writes ignored
    err_status_i = 32'hA5A5_0001; err_addr_lo_i = 32'h0000_F000; err_addr_hi_i = 32'h0000_00AB;
    pick(5, 3); rd(4'd8, v); chk("R8 error status", v, 32'hA5A5_0001);
    wr(4'd8, 32'h0);
    rd(4'd8, v); chk("R8 error status after write", v, 32'hA5A5_0001);
    pick(6, 0); rd(4'd8, v); chk("R8 error addr low", v, 32'h0000_F000);
    pick(7, 1); rd(4'd8, v); chk("R8 error addr high", v, 32'h0000_00AB);
    err_addr_hi_i = 32'h0000_00CD;
    rd(4'd8, v); chk("R8 error addr high tracks input", v, 32'h0000_00CD);
    chk_outputs("R8 outputs after error writes");

    // R9 every out-of-range function
    for (int fn = 8; fn < 256; fn++) begin
      pick(fn, fn & 3);
      wr(4'd8, 32'hFFFF_FFFF);
      rd(4'd8, v); chk("R9 bad function reads zero", v, 32'h0);
    end
    chk_outputs("R9 outputs after bad functions");

    // R11 flush bit
    pick(4, 0);
    wr(4'd8, 32'h0000_00F7); m_ctrl = 32'h0000_00F7;
    rd(4'd8, v); chk("R11 flush set", v, 32'h0000_00F7);
    repeat (3) @(negedge clk);
    rd(4'd8, v); chk("R11 flush held", v, 32'h0000_00F7);
    wr(4'd8, 32'h0000_00F5);
    rd(4'd8, v); chk("R11 write zero keeps flush", v, 32'h0000_00F7);
    @(negedge clk); flush_done_i = 1'b1;
    @(negedge clk); flush_done_i = 1'b0;
    rd(4'd8, v); chk("R11 flush cleared by done", v, 32'h0000_00F5);
    @(negedge clk);
    cfg_addr = 4'd8; cfg_wdata = 32'h0000_0002; cfg_wr = 1'b1; flush_done_i = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; flush_done_i = 1'b0;
    rd(4'd8, v); chk("R11 set wins over done", v, 32'h0000_0002);
    m_ctrl = 32'h0000_0002;

    // R13 gaps and misaligned offsets
    rd(4'd12, v); chk("R13 offset 12 reads zero", v, 32'h0);
    rd(4'd9, v);  chk("R13 misaligned window reads zero", v, 32'h0);
    rd(4'd1, v);  chk("R13 misaligned header reads zero", v, 32'h0);
    wr(4'd9, 32'h0);
    wr(4'd13, 32'h0);
    wr(4'd5, 32'h0000_0100);
    rd(4'd4, v); chk("R13 misaligned opsel write ignored", v, 32'h0000_0400);
    chk_outputs("R13 outputs after gap writes");

    // R12 reset again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NDOM; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    for (int i = 0; i < NMAP; i++) m_map[i] = '0;
    m_ctrl = '0;
    rd(4'd4, v); chk("R12 opsel after second reset", v, 32'h0);
    chk_outputs("R12 outputs after second reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule